// File: doc/BRIEF.md
# Ethernet Datapath Reset Distribution Controller

This block gathers the reset requests of an Ethernet port and fans them out to ten destination domains: TX MAC, RX MAC, TX PCS, RX PCS, TX PHY, RX PHY, TX statistics, RX statistics, MAC CSR and PHY CSR. The requests come from five active-low hard reset pins and from three software bits. The software bits are a full-system reset, a TX-only reset and an RX-only reset. They live in one control register, which is reached through a simple write/read port in the CSR clock domain.

The routing is deliberately uneven. A TX hard reset also clears the RX statistics counters. The TX soft reset does not clear them. Each domain reset is the OR of every source mapped to it. It asserts asynchronously and is released through a synchronizer chain clocked by that domain's own clock. The software bits never clear themselves: a domain held by a soft bit stays in reset until software writes the bit back to zero.

Top module: `eth_rst_dist`

## Requirements
- R1: The soft reset register is at address REG_ADDR. Bit 0 is the full-system soft reset, bit 1 is the TX soft reset and bit 2 is the RX soft reset. A write loads bits 2:0 from reg_wdata. A read at REG_ADDR returns the three bits in the same positions, with all other bits zero. The bits keep their value until the next write; they never clear themselves.
- R2: While csr_rst_n is low at a clk_csr rising edge, the soft bits are cleared to 0. While csr_rst_n is low, dom_rst_n[8] (MAC CSR) is asserted and no other domain is affected by it.
- R3: A write to any address other than REG_ADDR leaves the soft bits unchanged. A read at any other address returns zero.
- R4: A low sys_rst_n asserts domains 0 to 7 and leaves domains 8 and 9 untouched. The domain order is: 0 TX MAC, 1 RX MAC, 2 TX PCS, 3 RX PCS, 4 TX PHY, 5 RX PHY, 6 TX statistics, 7 RX statistics, 8 MAC CSR, 9 PHY CSR.
- R5: A low tx_rst_n asserts domains 0, 2, 4, 6 and 7.
- R6: A low rx_rst_n asserts domains 1, 3, 5 and 7.
- R7: A low reconfig_rst_n asserts domain 9 only.
- R8: The full-system soft bit asserts domains 0 to 7.
- R9: The TX soft bit asserts domains 0, 2, 4 and 6, and not domain 7.
- R10: The RX soft bit asserts domains 1, 3, 5 and 7.
- R11: A domain reset output (active low) goes low as soon as any mapped source asserts, without waiting for an edge of the domain clock.
- R12: After the last mapped source of a domain is released, the domain output is still low after the first rising edge of that domain's clock. It goes high after the second rising edge.
- R13: Each domain output is low exactly while at least one of its mapped sources is active. Releasing one of several active sources keeps the domain in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_csr | input | 1 | Clock of the register port |
| csr_rst_n | input | 1 | Active-low CSR hard reset; clears the soft bits and resets the MAC CSR domain |
| reconfig_rst_n | input | 1 | Active-low reset of the PHY CSR domain |
| sys_rst_n | input | 1 | Active-low general datapath hard reset |
| tx_rst_n | input | 1 | Active-low TX hard reset |
| rx_rst_n | input | 1 | Active-low RX hard reset |
| reg_wr | input | 1 | Write strobe, sampled at clk_csr rising edge |
| reg_addr | input | ADDR_W | Register address for writes and reads |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| dom_clk | input | 10 | Destination clock per domain |
| dom_rst_n | output | 10 | Active-low reset per domain, released in its own clock |

## Verification
Two things are hardest to reach from the ports. The first is the release timing of a single domain whose last source is a soft bit. Here the release starts at a clk_csr edge and has to be counted in edges of an unrelated clock. The bench clears the bit with a write and stops right after the clk_csr edge that takes the write. It then samples the chosen domain just after each of its next two clock edges. The domain clock's period is chosen so that its edges never land on a clk_csr edge. The second is overlap between sources. Random mixes of hard pins and soft bits are drawn, and sometimes the CSR reset is pulled in the middle of a mix so that it wipes the soft bits. Every domain is then compared with a bench model of the routing.

// File: rtl/eth_rst_pkg.sv
// Package: shared constants and the routing matrix of the reset distributor.
// Assumes ten fixed destination domains and eight reset sources, all active-high
// inside the block.
package eth_rst_pkg;

    localparam int NUM_DOM = 10;
    localparam int NUM_SRC = 8;
    localparam int SOFT_W  = 3;

    // Domain indices (the port vector order depends on these).
    localparam int D_TX_MAC  = 0;
    localparam int D_RX_MAC  = 1;
    localparam int D_TX_PCS  = 2;
    localparam int D_RX_PCS  = 3;
    localparam int D_TX_PHY  = 4;
    localparam int D_RX_PHY  = 5;
    localparam int D_TX_STAT = 6;
    localparam int D_RX_STAT = 7;
    localparam int D_MAC_CSR = 8;
    localparam int D_PHY_CSR = 9;

    // Source indices.
    localparam int S_SYS_HARD = 0;
    localparam int S_TX_HARD  = 1;
    localparam int S_RX_HARD  = 2;
    localparam int S_CSR_HARD = 3;
    localparam int S_CFG_HARD = 4;
    localparam int S_SYS_SOFT = 5;
    localparam int S_TX_SOFT  = 6;
    localparam int S_RX_SOFT  = 7;

    // Soft register bit positions.
    localparam int B_SYS = 0;
    localparam int B_TX  = 1;
    localparam int B_RX  = 2;

    typedef logic [NUM_DOM-1:0] dom_vec_t;

    // Returns the set of domains a source drives into reset.
    function automatic dom_vec_t route_mask(input int src);
        dom_vec_t m;
        m = '0;
        case (src)
            S_SYS_HARD, S_SYS_SOFT: begin
                for (int d = D_TX_MAC; d <= D_RX_STAT; d++) m[d] = 1'b1;
            end
            S_TX_HARD: begin
                m[D_TX_MAC] = 1'b1; m[D_TX_PCS] = 1'b1; m[D_TX_PHY] = 1'b1;
                m[D_TX_STAT] = 1'b1; m[D_RX_STAT] = 1'b1;
            end
            S_TX_SOFT: begin
                m[D_TX_MAC] = 1'b1; m[D_TX_PCS] = 1'b1; m[D_TX_PHY] = 1'b1;
                m[D_TX_STAT] = 1'b1;
            end
            S_RX_HARD, S_RX_SOFT: begin
                m[D_RX_MAC] = 1'b1; m[D_RX_PCS] = 1'b1; m[D_RX_PHY] = 1'b1;
                m[D_RX_STAT] = 1'b1;
            end
            S_CSR_HARD: m[D_MAC_CSR] = 1'b1;
            S_CFG_HARD: m[D_PHY_CSR] = 1'b1;
            default:    m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rst_soft_reg.sv
// Module: soft reset control register with a single-address write/read port.
// Assumes a synchronous active-low reset in the clk domain. The soft bits are
// level-held and never self-clear. Reads are combinational on the address.
module rst_soft_reg
    import eth_rst_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [SOFT_W-1:0] soft_q
);

    logic wr_hit;
    logic unused_wdata_hi;

    assign wr_hit          = wr && (addr == REG_ADDR);
    assign unused_wdata_hi = ^wdata[DATA_W-1:SOFT_W];

    // Hold the soft bits; load them on an addressed write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      soft_q <= '0;
        else if (wr_hit) soft_q <= wdata[SOFT_W-1:0];
    end

    // Return the soft bits at the register address, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (addr == REG_ADDR) rdata[SOFT_W-1:0] = soft_q;
    end

    // R1
    soft_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> soft_q == $past(wdata[SOFT_W-1:0]));

    // R3
    soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(soft_q));

    // R2
    soft_clear_chk: assert property (@(posedge clk)
        !rst_n |=> soft_q == '0);

endmodule

// File: rtl/rst_route_matrix.sv
// Module: combinational routing of active-high reset sources to domain requests.
// Assumes all sources are already active-high. Each domain request is the OR of
// every source whose route mask covers that domain.
module rst_route_matrix
    import eth_rst_pkg::*;
(
    input  logic [NUM_SRC-1:0] src_act,
    output logic [NUM_DOM-1:0] dom_req
);

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        logic [NUM_SRC-1:0] hit;
        // Collect the sources that reach domain d.
        always_comb begin
            for (int s = 0; s < NUM_SRC; s++) begin
                hit[s] = src_act[s] & route_mask(s)[d];
            end
        end
        assign dom_req[d] = |hit;
    end

endmodule

// File: rtl/rst_sync_cell.sv
// Module: reset synchronizer for one destination domain.
// The request clears the chain asynchronously, so the block's reset style
// (synchronous) is set aside on purpose here. Release ripples through STAGES
// flops clocked by the destination clock. Assumes STAGES >= 2.
module rst_sync_cell #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic req,
    output logic rst_n_o
);

    logic [STAGES-1:0] chain;

    // Clear at once on request; shift ones in after release.
    always_ff @(posedge clk or posedge req) begin
        if (req) chain <= '0;
        else     chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign rst_n_o = chain[STAGES-1];

    // R11
    req_holds_chk: assert property (@(posedge clk) disable iff (1'b0)
        req |-> !rst_n_o);

endmodule

// File: rtl/eth_rst_dist.sv
// Module: top of the Ethernet reset distributor.
// It turns the hard pins into active-high sources, adds the soft register bits,
// routes them through the matrix and synchronizes each domain output to its
// own clock. Assumes dom_clk bits are free-running whenever release is expected.
module eth_rst_dist
    import eth_rst_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 32,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h10,
    parameter int                SYNC_STAGES = 2
) (
    input  logic               clk_csr,
    input  logic               csr_rst_n,
    input  logic               reconfig_rst_n,
    input  logic               sys_rst_n,
    input  logic               tx_rst_n,
    input  logic               rx_rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_DOM-1:0] dom_clk,
    output logic [NUM_DOM-1:0] dom_rst_n
);

    logic [SOFT_W-1:0]  soft_q;
    logic [NUM_SRC-1:0] src_act;
    logic [NUM_DOM-1:0] dom_req;

    rst_soft_reg #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .REG_ADDR(REG_ADDR)
    ) i_soft_reg (
        .clk   (clk_csr),
        .rst_n (csr_rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .soft_q(soft_q)
    );

    // Gather all sources as active-high requests.
    always_comb begin
        src_act             = '0;
        src_act[S_SYS_HARD] = !sys_rst_n;
        src_act[S_TX_HARD]  = !tx_rst_n;
        src_act[S_RX_HARD]  = !rx_rst_n;
        src_act[S_CSR_HARD] = !csr_rst_n;
        src_act[S_CFG_HARD] = !reconfig_rst_n;
        src_act[S_SYS_SOFT] = soft_q[B_SYS];
        src_act[S_TX_SOFT]  = soft_q[B_TX];
        src_act[S_RX_SOFT]  = soft_q[B_RX];
    end

    rst_route_matrix i_matrix (
        .src_act(src_act),
        .dom_req(dom_req)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_sync
        rst_sync_cell #(.STAGES(SYNC_STAGES)) i_sync (
            .clk    (dom_clk[d]),
            .req    (dom_req[d]),
            .rst_n_o(dom_rst_n[d])
        );
    end

    // R5
    tx_pin_rx_stat_chk: assert property (@(posedge dom_clk[D_RX_STAT]) disable iff (1'b0)
        !tx_rst_n |-> !dom_rst_n[D_RX_STAT]);

    // R2
    csr_pin_mac_csr_chk: assert property (@(posedge dom_clk[D_MAC_CSR]) disable iff (1'b0)
        !csr_rst_n |-> !dom_rst_n[D_MAC_CSR]);

endmodule

// File: tb/test_eth_rst_dist.sv
`timescale 1ns/1ps
module test_eth_rst_dist;

    localparam logic [7:0] RA = 8'h10;

    logic        clk_csr = 1'b0;
    logic        csr_rst_n, reconfig_rst_n, sys_rst_n, tx_rst_n, rx_rst_n;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [9:0]  dom_clk;
    logic [9:0]  dom_rst_n;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    eth_rst_dist i_eth_rst_dist (
        .clk_csr(clk_csr), .csr_rst_n(csr_rst_n), .reconfig_rst_n(reconfig_rst_n),
        .sys_rst_n(sys_rst_n), .tx_rst_n(tx_rst_n), .rx_rst_n(rx_rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dom_clk(dom_clk), .dom_rst_n(dom_rst_n)
    );

    always #2 clk_csr = ~clk_csr;

    for (genvar g = 0; g < 10; g++) begin : g_clk
        initial begin
            dom_clk[g] = 1'b0;
            forever #(1.3 + 0.3 * g) dom_clk[g] = ~dom_clk[g];
        end
    end

    // Expected active-low domain outputs from the requirement routing.
    function automatic logic [9:0] exp_n(logic s_n, logic t_n, logic r_n,
                                         logic c_n, logic f_n, logic [2:0] sb);
        logic [9:0] r = '0;
        if (!s_n) r |= 10'h0FF;   // R4
        if (!t_n) r |= 10'h0D5;   // R5
        if (!r_n) r |= 10'h0AA;   // R6
        if (!c_n) r |= 10'h100;   // R2
        if (!f_n) r |= 10'h200;   // R7
        if (sb[0]) r |= 10'h0FF;  // R8
        if (sb[1]) r |= 10'h055;  // R9
        if (sb[2]) r |= 10'h0AA;  // R10
        return ~r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [7:0] a, logic [31:0] d);
        @(negedge clk_csr);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk_csr);
        reg_wr = 1'b0; reg_addr = RA;
    endtask

    task automatic settle();
        repeat (20) @(posedge clk_csr);
        #1;
    endtask

    task automatic set_hard(logic [4:0] h);
        {reconfig_rst_n, csr_rst_n, rx_rst_n, tx_rst_n, sys_rst_n} = h;
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] sw;
        logic [4:0] hv;
        string tags [8];
        void'($urandom(32'h5EED_1234));
        tags = '{"R4", "R5", "R6", "R2", "R7", "R8", "R9", "R10"};
        reg_wr = 0; reg_addr = RA; reg_wdata = 0;
        set_hard(5'b00000);
        settle();
        // Reset state: everything held, register cleared (R2)
        chk("R2 reset outputs", {22'd0, dom_rst_n}, 32'd0);
        chk("R2 reset register", reg_rdata, 32'd0);
        set_hard(5'b11111);
        settle();
        chk("R13 all released", {22'd0, dom_rst_n}, 32'h3FF);

        // Each source alone, one requirement each
        for (int s = 0; s < 8; s++) begin
            logic [4:0] h = 5'b11111;
            logic [2:0] b = 3'b000;
            if (s < 5) h[s] = 1'b0; else b[s-5] = 1'b1;
            wr_reg(RA, {29'd0, b});
            set_hard(h);
            settle();
            chk(tags[s], {22'd0, dom_rst_n}, {22'd0, exp_n(h[0], h[1], h[2], h[3], h[4], b)});
            set_hard(5'b11111);
            wr_reg(RA, 0);
            settle();
        end

        // R1: register readback, held over time, upper bits read zero
        wr_reg(RA, 32'hFFFF_FFF5);
        settle();
        chk("R1 readback", reg_rdata, 32'h5);
        repeat (50) @(posedge clk_csr);
        #1;
        chk("R1 no self-clear", reg_rdata, 32'h5);
        chk("R1 outputs held", {22'd0, dom_rst_n}, {22'd0, exp_n(1, 1, 1, 1, 1, 3'b101)});

        // R3: write elsewhere ignored, read elsewhere zero
        wr_reg(RA + 8'h4, 32'h0);
        settle();
        chk("R3 stray write", reg_rdata, 32'h5);
        reg_addr = 8'h00; #0.1;
        chk("R3 stray read", reg_rdata, 32'h0);
        reg_addr = RA;
        chk("R3 outputs kept", {22'd0, dom_rst_n}, {22'd0, exp_n(1, 1, 1, 1, 1, 3'b101)});
        wr_reg(RA, 0);
        settle();

        // R11: asynchronous assertion
        chk("R11 before", {31'd0, dom_rst_n[1]}, 32'd1);
        rx_rst_n = 1'b0;
        #0.01;
        chk("R11 async assert", {31'd0, dom_rst_n[1]}, 32'd0);
        settle();
        // R13: release one of two sources, domain 7 stays held
        tx_rst_n = 1'b0;
        settle();
        rx_rst_n = 1'b1;
        settle();
        chk("R13 overlap hold", {31'd0, dom_rst_n[7]}, 32'd0);
        tx_rst_n = 1'b1;
        settle();

        // R12: soft RX release timed in domain 3 clock
        wr_reg(RA, 32'h4);
        settle();
        @(negedge clk_csr);
        reg_wr = 1'b1; reg_wdata = 32'h0;
        @(posedge clk_csr);
        #0.01;
        reg_wr = 1'b0;
        @(posedge dom_clk[3]); #0.05;
        chk("R12 first edge low", {31'd0, dom_rst_n[3]}, 32'd0);
        @(posedge dom_clk[3]); #0.05;
        chk("R12 second edge high", {31'd0, dom_rst_n[3]}, 32'd1);
        settle();

        // Random mixes (R13), sometimes wiping soft bits with the CSR reset (R2)
        for (int it = 0; it < 40; it++) begin
            sw = 3'b000;
            for (int k = 0; k < 3; k++) sw[k] = ($urandom % 3) == 0;
            hv = 5'b11111;
            for (int k = 0; k < 5; k++) if (k != 3) hv[k] = ($urandom % 4) != 0;
            csr_rst_n = 1'b1;
            wr_reg(RA, {$urandom, 3'b000} | {29'd0, sw});
            if (($urandom % 4) == 0) begin
                hv[3] = 1'b0;
                sw = 3'b000;
            end
            set_hard(hv);
            settle();
            chk("R13 random mix", {22'd0, dom_rst_n}, {22'd0, exp_n(hv[0], hv[1], hv[2], hv[3], hv[4], sw)});
            chk("R2 random reg", reg_rdata, {29'd0, sw});
            set_hard(5'b11111);
        end
        wr_reg(RA, 0);
        settle();
        chk("R13 final release", {22'd0, dom_rst_n}, 32'h3FF);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule